// File: doc/BRIEF.md
# Four-State Loop Sequencer with Reversal and Skip

This block is a small clocked controller that walks through four states, called A, B, C and D, in an endless loop. One control input picks the direction of travel around the loop and a second control input shortens the loop by sending state A straight to state C. The present state leaves the block as a 2-bit registered code.

The state moves by one transition on each clock edge where the step enable is high. Both control inputs are sampled on that same edge, so a change in either one only affects the transition that follows it. A synchronous reset puts the controller in state A. Every state has a defined successor for each combination of the two control inputs, so the loop never locks up and never stops.

Top module: `seq4_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes A (code 00) on that edge, whatever `step_en`, `dir_rev` and `skip_en` are.
- R2: With `step_en` low at a rising edge and `rst` low, `state_code` keeps its value.
- R3: With `step_en` high, `dir_rev` low and `skip_en` low, the state moves forward around the loop A(00), B(01), C(10), D(11) and back to A.
- R4: With `step_en` high, `dir_rev` high and `skip_en` low, the state moves backward around the loop D(11), C(10), B(01), A(00) and back to D.
- R5: With `step_en` high, `skip_en` high and the present state A, the next state is C (10) for either value of `dir_rev`.
- R6: With `skip_en` high and the present state not A, the step follows `dir_rev` exactly as in R3 and R4, so the forward loop is A, C, D and the backward loop is C, B, A.
- R7: Values on `dir_rev` and `skip_en` while `step_en` is low change nothing. Only the values present on an enabled edge decide that edge's transition.
- R8: The state is shown on `state_code` as A=00, B=01, C=10, D=11, straight from a register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to state A |
| step_en | input | 1 | Advance one state on this edge when high |
| dir_rev | input | 1 | Direction select: 0 forward, 1 backward |
| skip_en | input | 1 | When high, state A is followed by C |
| state_code | output | 2 | Registered present state, A=00 to D=11 |

## Verification
The assertions assume that `step_en`, `dir_rev` and `skip_en` are already synchronous to `clk` and settled before each rising edge. They also assume that no transition is expected on an edge where `rst` is high. The bench drives every input on the falling edge so that the values are stable at the rising edge. It holds reset for only a few scattered cycles. Its random mix lets the control inputs toggle while `step_en` is low, which is the case where a design that samples them early would go wrong.

// File: rtl/seq4_pkg.sv
package seq4_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    ST_A = 2'b00,
    ST_B = 2'b01,
    ST_C = 2'b10,
    ST_D = 2'b11
  } loop_state_t;
endpackage

// File: rtl/seq4_step_logic.sv
// Combinational successor selection for the four-state loop.
module seq4_step_logic
  import seq4_pkg::*;
(
  input  loop_state_t cur,
  input  logic        rev,
  input  logic        skip,
  output loop_state_t nxt
);
  always_comb begin
    if (skip && cur == ST_A) begin
      nxt = ST_C;                     // shortcut wins over direction
    end else if (rev) begin
      unique case (cur)
        ST_A: nxt = ST_D;
        ST_B: nxt = ST_A;
        ST_C: nxt = ST_B;
        default: nxt = ST_C;
      endcase
    end else begin
      unique case (cur)
        ST_A: nxt = ST_B;
        ST_B: nxt = ST_C;
        ST_C: nxt = ST_D;
        default: nxt = ST_A;
      endcase
    end
  end
endmodule

// File: rtl/seq4_state_reg.sv
// Enable-gated register with synchronous reset value.
module seq4_state_reg #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (en) q <= d;
  end
endmodule

// File: rtl/seq4_ctrl.sv
module seq4_ctrl
  import seq4_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step_en,
  input  logic              dir_rev,
  input  logic              skip_en,
  output logic [CODE_W-1:0] state_code
);
  loop_state_t cur_st;
  loop_state_t nxt_st;
  logic [CODE_W-1:0] q_raw;

  assign cur_st = loop_state_t'(q_raw);

  seq4_step_logic u_step (
    .cur  (cur_st),
    .rev  (dir_rev),
    .skip (skip_en),
    .nxt  (nxt_st)
  );

  seq4_state_reg #(.W(CODE_W), .RST_VAL(ST_A)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (step_en),
    .d   (nxt_st),
    .q   (q_raw)
  );

  assign state_code = q_raw;

  // Reset lands in A on the following edge.
  assert_reset_to_a_R1: assert property (@(posedge clk)
    rst |=> state_code == 2'b00);

  // No enable, no movement.
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(state_code));

  // Forward step outside the shortcut.
  assert_forward_R3: assert property (@(posedge clk) disable iff (rst)
    (step_en && !dir_rev && !(skip_en && state_code == 2'b00))
      |=> state_code == 2'($past(state_code) + 2'd1));

  // Backward step outside the shortcut.
  assert_backward_R4: assert property (@(posedge clk) disable iff (rst)
    (step_en && dir_rev && !(skip_en && state_code == 2'b00))
      |=> state_code == 2'($past(state_code) - 2'd1));

  // Shortcut from A goes to C in both directions.
  assert_skip_a_to_c_R5: assert property (@(posedge clk) disable iff (rst)
    (step_en && skip_en && state_code == 2'b00) |=> state_code == 2'b10);

  // The state B is never reached straight from A while the shortcut is on.
  assert_skip_no_b_R6: assert property (@(posedge clk) disable iff (rst)
    (step_en && skip_en && state_code == 2'b00) |=> state_code != 2'b01);
endmodule

// File: tb/seq4_ctrl_tb.sv
`timescale 1ns/1ps
module seq4_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       step_en;
  logic       dir_rev;
  logic       skip_en;
  logic [1:0] state_code;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 1'b0;
  logic [1:0] exp_st = 2'b00;

  always #2 clk = ~clk;

  seq4_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .dir_rev    (dir_rev),
    .skip_en    (skip_en),
    .state_code (state_code)
  );

  // Independent successor model written from the requirements.
  function automatic logic [1:0] model_next(input logic [1:0] s, input logic y, input logic z);
    if (z && s == 2'b00) return 2'b10;                         // R5
    if (y) return (s == 2'b00) ? 2'b11 : s - 2'b01;             // R4
    return (s == 2'b11) ? 2'b00 : s + 2'b01;                    // R3
  endfunction

  function automatic string pick_tag(input logic r, input logic s, input logic y,
                                     input logic z, input logic [1:0] cur);
    if (r)  return "R1";
    if (!s) return (y || z) ? "R7" : "R2";
    if (z && cur == 2'b00) return "R5";
    if (z) return "R6";
    return y ? "R4" : "R3";
  endfunction

  // Called on a falling edge: drive, wait one full cycle, compare.
  task automatic apply(input logic r, input logic s, input logic y, input logic z,
                       input string tag_in);
    string tag;
    tag = (tag_in == "") ? pick_tag(r, s, y, z, exp_st) : tag_in;
    rst = r; step_en = s; dir_rev = y; skip_en = z;
    if (r)      exp_st = 2'b00;
    else if (s) exp_st = model_next(exp_st, y, z);
    @(negedge clk);
    n_vec++;
    if (state_code !== exp_st) begin
      n_miss++;
      $display("FAIL %s: state_code=%b expected=%b", tag, state_code, exp_st);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; step_en = 1'b1; dir_rev = 1'b1; skip_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    n_vec++;
    if (state_code !== 2'b00) begin
      n_miss++;
      $display("FAIL R1: state_code=%b expected=00 after reset", state_code);
    end
    exp_st = 2'b00;

    // R8 and R3: forward walk shows each code in turn.
    for (int i = 0; i < 8; i++) apply(1'b0, 1'b1, 1'b0, 1'b0, "R8");
    // R4: backward walk.
    for (int i = 0; i < 8; i++) apply(1'b0, 1'b1, 1'b1, 1'b0, "R4");
    // R5, R6: forward short loop, then backward short loop.
    apply(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 6; i++) apply(1'b0, 1'b1, 1'b0, 1'b1, "");
    apply(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 6; i++) apply(1'b0, 1'b1, 1'b1, 1'b1, "");
    // R7: toggle controls with step low, then one forward step.
    apply(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    apply(1'b0, 1'b0, 1'b1, 1'b1, "R7");
    apply(1'b0, 1'b0, 1'b0, 1'b1, "R7");
    apply(1'b0, 1'b1, 1'b0, 1'b0, "R7");
    // R2: hold with all controls low.
    apply(1'b0, 1'b0, 1'b0, 1'b0, "R2");
    // R1: reset wins over an active step.
    apply(1'b1, 1'b1, 1'b1, 1'b1, "R1");

    for (int i = 0; i < 3000; i++) begin
      logic r, s, y, z;
      r = ($urandom_range(0, 49) == 0);
      s = ($urandom_range(0, 3) != 0);
      y = $urandom_range(0, 1) == 1;
      z = $urandom_range(0, 2) == 0;
      apply(r, s, y, z, "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule